// File: doc/BRIEF.md
# Dual-Port Two-Beat Synchronous SRAM with Lane Masks

This block is a small synchronous memory with a read port and a write port that run side by side on one clock and share a single address bus. Every accepted command moves two data words. The first word goes to or comes from the base address, and the second to or from the base address plus one.

A write is spread over two clock edges. On the first edge the write enable is low, and the block captures the first data word and its lane mask. On the next edge the block takes the write address from the shared bus, along with the second data word and its mask. Both words are committed on that second edge.

A read takes its address on the same edge as its enable. It returns its two words two and three cycles later, with a valid flag. Each lane mask bit is active low and guards one equal slice of the data word. The default is 18 bits in two 9-bit lanes. An 8-bit, two-lane build gives 4-bit nibble lanes.

Top module: `sepport_sram`

## Requirements
- R1: While `rst_n` is low, every location is cleared to zero, `rvalid` is driven low and `rdata` is driven to zero.
- R2: When `rd_n` is low on edge N and the read port is idle, the block samples `addr` as A. After edge N+2, `rdata` holds word A with `rvalid` high. After edge N+3, `rdata` holds word A+1 with `rvalid` high.
- R3: On a cycle with no read beat due, `rvalid` is low and `rdata` keeps its previous value.
- R4: When `wr_n` is low on edge N and the write port is idle, the block captures `wdata` and `wmask_n` as beat one. On edge N+1 it takes `addr` as the base B, and `wdata` and `wmask_n` as beat two. Beat one is written to B and beat two to B+1.
- R5: A high `wr_n` on an edge where the write port is idle starts no write, and no location changes.
- R6: Lane i is bits [i*DW/NB +: DW/NB]. Mask bit i low writes lane i of its beat. Mask bit i high leaves lane i of the target word unchanged. Each beat uses its own mask.
- R7: Base plus one wraps modulo 2^AW, so a base of 63 pairs with location 0.
- R8: A read returns the contents committed before its own sampling edge. A write whose address edge is that same edge is not seen by the read.
- R9: A low `wr_n` on a write's address edge is ignored. A low `rd_n` on the edge right after an accepted read is ignored.
- R10: A read and a write may be accepted on the same edge, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Shared address bus |
| rd_n | input | 1 | Read enable, active low |
| wr_n | input | 1 | Write enable, active low |
| wdata | input | DW | Write data, one beat per edge |
| wmask_n | input | NB | Lane masks, active low, sampled with each beat |
| rdata | output | DW | Read data beat |
| rvalid | output | 1 | High when `rdata` carries a read beat |

## Verification
The bench aims at the rule that a write's address arrives one edge after its command. It runs a read on that same edge to the same location. A design that commits too early, or that forwards data, would return the new words where the old ones are due.

The bench applies split masks on the two beats, and then a fully masked write. A design that shares one mask across both beats, or that swaps the lanes, would corrupt the untouched halves.

A base at the top of the address space checks that the second word wraps to location zero, not to a location out of range.

Two further cases probe the busy rules. A write enable on an address edge must not start a phantom write, and a read enable right after a read must not collide with the second beat.

// File: rtl/sepport_sram.sv
module sepport_sram #(
  parameter int AW = 6,
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] wmask_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int LW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_nx;
  logic          rd_stg1, rd_stg2, beat2_pend, wr_ph;
  logic [DW-1:0] s1a, s1b, s2a, s2b, wd1;
  logic [NB-1:0] wm1;
  logic          rd_go, wr_go;

  assign addr_nx = addr + 1'b1;
  assign rd_go   = !rd_n && !rd_stg1;
  assign wr_go   = !wr_n && !wr_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_ph) begin
      for (int i = 0; i < NB; i++) begin
        if (!wm1[i])     mem[addr][i*LW +: LW]    <= wd1[i*LW +: LW];
        if (!wmask_n[i]) mem[addr_nx][i*LW +: LW] <= wdata[i*LW +: LW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ph <= 1'b0;
      wd1   <= '0;
      wm1   <= '1;
    end else begin
      wr_ph <= wr_go;
      if (wr_go) begin
        wd1 <= wdata;
        wm1 <= wmask_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_stg1    <= 1'b0;
      rd_stg2    <= 1'b0;
      beat2_pend <= 1'b0;
      s1a <= '0; s1b <= '0; s2a <= '0; s2b <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rd_stg1 <= rd_go;
      if (rd_go) begin
        s1a <= mem[addr];
        s1b <= mem[addr_nx];
      end
      rd_stg2 <= rd_stg1;
      if (rd_stg1) begin
        s2a <= s1a;
        s2b <= s1b;
      end
      beat2_pend <= rd_stg2;
      if (rd_stg2) begin
        rdata  <= s2a;
        rvalid <= 1'b1;
      end else if (beat2_pend) begin
        rdata  <= s2b;
        rvalid <= 1'b1;
      end else begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sepport_sram_chk.sv
module sepport_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rvalid,
  input logic [DW-1:0] rdata,
  input logic          rd_stg1,
  input logic          wr_ph
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!rvalid && rdata == '0)); // R1
  AST_READ_BEAT1: assert property (@(posedge clk) disable iff (!rst_n) rd_stg1 |=> ##1 rvalid); // R2
  AST_READ_BEAT2: assert property (@(posedge clk) disable iff (!rst_n) rd_stg1 |=> ##2 rvalid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rvalid |-> $stable(rdata)); // R3
  AST_WRITE_START: assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && !wr_ph) |=> wr_ph); // R4
  AST_WR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) wr_ph |=> !wr_ph); // R9
  AST_RD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) rd_stg1 |=> !rd_stg1); // R9
endmodule

bind sepport_sram sepport_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rvalid(rvalid), .rdata(rdata),
  .rd_stg1(rd_stg1), .wr_ph(wr_ph)
);

// File: tb/sepport_sram_tb.sv
module sepport_sram_tb;
  localparam int AW = 6, DW = 18, NB = 2, LW = DW / NB;
  localparam int NV = 24;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic rd_n = 1, wr_n = 1;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] wmask_n = '1;
  logic [DW-1:0] rdata;
  logic rvalid;

  sepport_sram #(.AW(AW), .DW(DW), .NB(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .wdata(wdata), .wmask_n(wmask_n), .rdata(rdata), .rvalid(rvalid)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] ref_m [1 << AW];
  logic          exp_v [256];
  logic [DW-1:0] exp_d [256];
  logic [DW-1:0] last_d;
  logic          m_rbusy, m_wph;
  logic [DW-1:0] m_wd1;
  logic [NB-1:0] m_wm1;
  int t;

  // {rd_n, wr_n, addr, wdata, wmask_n}
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd0,  18'h12345, 2'b00},  // R4 command, beat one
    {1'b1, 1'b1, 6'd5,  18'h0ABCD, 2'b00},  // R4 address edge, beat two
    {1'b0, 1'b1, 6'd5,  18'h3FFFF, 2'b11},  // R2 read 5; R5 junk on idle write
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b11},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b11},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b11},
    {1'b0, 1'b0, 6'd5,  18'h3FFFF, 2'b10},  // R10 read and write together; R6 beat one lane 0
    {1'b1, 1'b0, 6'd5,  18'h3FFFF, 2'b01},  // R6 beat two lane 1; R9 wr_n ignored
    {1'b0, 1'b1, 6'd5,  18'h00000, 2'b00},  // read sees masked result
    {1'b0, 1'b1, 6'd9,  18'h00000, 2'b00},  // R9 read ignored
    {1'b1, 1'b0, 6'd0,  18'h00001, 2'b00},
    {1'b0, 1'b1, 6'd63, 18'h00002, 2'b00},  // R8 read on commit edge; R7 wrap
    {1'b1, 1'b1, 6'd63, 18'h3FFFF, 2'b00},  // R5 deselect
    {1'b0, 1'b1, 6'd63, 18'h00000, 2'b00},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b00},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b00},
    {1'b1, 1'b0, 6'd0,  18'h3FFFF, 2'b11},  // R6 fully masked
    {1'b1, 1'b1, 6'd5,  18'h00000, 2'b11},
    {1'b0, 1'b1, 6'd5,  18'h00000, 2'b00},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b00},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b00},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b00},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b00},
    {1'b1, 1'b1, 6'd0,  18'h00000, 2'b00}
  };

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < (1 << AW); k++) ref_m[k] = '0;
    for (int k = 0; k < 256; k++) exp_v[k] = 1'b0;
    last_d = '0; m_rbusy = 0; m_wph = 0; m_wd1 = '0; m_wm1 = '1;
  endtask

  task automatic cyc(input logic r, w, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [NB-1:0] m);
    logic racc, wacc;
    logic [AW-1:0] an;
    @(negedge clk);
    if (exp_v[t % 256]) begin
      chk(rvalid === 1'b1 && rdata === exp_d[t % 256], "R2 R8 beat", rdata, exp_d[t % 256]);
      last_d = exp_d[t % 256];
    end else begin
      chk(rvalid === 1'b0 && rdata === last_d, "R3 idle hold", rdata, last_d);
    end
    exp_v[t % 256] = 1'b0;
    rd_n = r; wr_n = w; addr = a; wdata = d; wmask_n = m;
    @(posedge clk);
    t++;
    an = a + 1'b1;
    racc = !r && !m_rbusy;
    wacc = !w && !m_wph;
    if (racc) begin
      exp_v[(t + 2) % 256] = 1'b1; exp_d[(t + 2) % 256] = ref_m[a];
      exp_v[(t + 3) % 256] = 1'b1; exp_d[(t + 3) % 256] = ref_m[an];
    end
    if (m_wph)
      for (int i = 0; i < NB; i++) begin
        if (!m_wm1[i]) ref_m[a][i*LW +: LW] = m_wd1[i*LW +: LW];
        if (!m[i])     ref_m[an][i*LW +: LW] = d[i*LW +: LW];
      end
    m_rbusy = racc;
    m_wph = wacc;
    if (wacc) begin m_wd1 = d; m_wm1 = m; end
  endtask

  task automatic rd_pair(input logic [AW-1:0] a, input logic [DW-1:0] e1, e2, input string req);
    cyc(1'b0, 1'b1, a, '0, '1);
    cyc(1'b1, 1'b1, '0, '0, '1);
    cyc(1'b1, 1'b1, '0, '0, '1);
    #1 chk(rvalid === 1'b1 && rdata === e1, req, rdata, e1);
    cyc(1'b1, 1'b1, '0, '0, '1);
    #1 chk(rvalid === 1'b1 && rdata === e2, req, rdata, e2);
    cyc(1'b1, 1'b1, '0, '0, '1);
    cyc(1'b1, 1'b1, '0, '0, '1);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 chk(rvalid === 1'b0 && rdata === '0, "R1 reset outputs", rdata, '0);
    @(negedge clk) rst_n = 1;
    for (int v = 0; v < NV; v++)
      cyc(VEC[v][27], VEC[v][26], VEC[v][25:20], VEC[v][19:2], VEC[v][1:0]);
    rd_pair(6'd5, 18'h123FF, 18'h3FFCD, "R6 split masks, R9 no phantom write");
    rd_pair(6'd63, 18'h00001, 18'h00002, "R7 wrap to zero, R4 both beats");
    rd_pair(6'd20, 18'h00000, 18'h00000, "R5 untouched location");
    @(negedge clk) rst_n = 0;
    model_reset();
    repeat (2) @(posedge clk);
    #1 chk(rvalid === 1'b0 && rdata === '0, "R1 mid-run reset", rdata, '0);
    @(negedge clk) rst_n = 1;
    rd_pair(6'd5, 18'h00000, 18'h00000, "R1 memory cleared");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule